// File: doc/BRIEF.md
# Two-Level Multi-CPU Interrupt Controller

This block gathers level-sensitive interrupt lines from devices and delivers them to a small set of CPUs. Every source passes two gates before it reaches a CPU. The first is a global enable bit that all CPUs share. The second is a mask bit that each CPU holds for itself. Each source also has a control word that names the CPUs it may reach.

Software reaches the block through one register port with two windows. The shared window holds the source count, the global enable set/clear registers and the per-source control words. The per-CPU window decodes to the registers of the CPU that issues the access, as given by `bus_cpu`. It holds the mask set/clear registers, a bitmap of pending low-numbered sources, and an acknowledge register. The acknowledge register returns the lowest eligible source ID.

Enable and mask updates do not take a bitmask. Software writes a source ID to a set register or to a clear register. Each CPU has a registered interrupt output. That output is high while any source is eligible for that CPU.

Top module: `dual_mask_intc`

## Requirements
- R1: A read of shared offset 0x00 returns the number of implemented sources (`NUM_SRC`) in bits [12:2], with all other bits zero. Writes to this offset change nothing.
- R2: Writing an ID to shared offset 0x30 sets that source's global enable, and writing an ID to shared offset 0x34 clears it. The ID is taken from write data bits [9:0]. A write whose ID is `NUM_SRC` or greater changes no state, even if its low bits match an implemented source.
- R3: Writing an ID to per-CPU offset 0x48 masks that source for the CPU given by `bus_cpu`, and writing an ID to per-CPU offset 0x4C unmasks it for that CPU only. No other CPU's mask changes.
- R4: The control word of source ID sits at shared offset 0x100 + 4·ID. Bit (0+cpu) is the IRQ route bit for that CPU and bit (8+cpu) is the FIQ route bit. The word reads back what was written, except that bits for unimplemented CPUs and all other bits read as zero.
- R5: A source is eligible for a CPU when all of these hold: its line is high, it is globally enabled, it is unmasked for that CPU, and either its IRQ route bit or its FIQ route bit for that CPU is set.
- R6: `cpu_irq[c]` is the OR of all sources eligible for CPU c. It is registered, so it follows a change on the source lines, or a register write, one clock edge after that change takes effect.
- R7: A read of per-CPU offset 0x44 returns, in bits [9:0], the lowest ID eligible for the accessing CPU, or 1023 when none is eligible. The read has no side effect: the same read repeated returns the same ID.
- R8: A read of per-CPU offset 0x10 returns a bitmap. Bit i is set when source i is eligible for the accessing CPU, for i below 29. Bits 29 and up are always zero.
- R9: Read data appears on `bus_rdata` with `bus_rvalid` high in the cycle after the read request. Unmapped offsets, and control words beyond the last source, read as zero.
- R10: After reset every source is disabled, every source is masked for every CPU, every control word is zero, every `cpu_irq` bit is low and both acknowledge registers return 1023.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_level | input | NUM_SRC | Level-sensitive interrupt lines, one per source ID |
| bus_valid | input | 1 | Register access request, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_local | input | 1 | 0 = shared window, 1 = per-CPU window |
| bus_cpu | input | CPU_W | ID of the CPU making the access |
| bus_addr | input | ADDR_W | Byte offset within the selected window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| cpu_irq | output | NUM_CPU | Registered interrupt request to each CPU |

## Verification
The bench builds the block with 40 sources and 2 CPUs. Forty is above 29, so some IDs are eligible but never appear in the pending bitmap. It is also below 64, so the ID 69 aliases source 5 in its low six bits, and a write of that ID exposes a missing range check. With two CPUs, route bits 2, 3, 10 and 11 are unimplemented, which makes their read-as-zero behaviour observable. The bench also covers two cases at once: routing one source through its FIQ bit to one CPU while another CPU keeps it masked.

// File: rtl/dmi_pkg.sv
package dmi_pkg;
  localparam int ID_W        = 10;
  localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;
  localparam int LOCAL_LIMIT = 29;

  // shared window offsets
  localparam int OFS_CTRL    = 'h000;
  localparam int OFS_EN_SET  = 'h030;
  localparam int OFS_EN_CLR  = 'h034;
  localparam int OFS_ROUTE   = 'h100;

  // per-CPU window offsets
  localparam int OFS_CAUSE   = 'h010;
  localparam int OFS_ACK     = 'h044;
  localparam int OFS_MSK_SET = 'h048;
  localparam int OFS_MSK_CLR = 'h04C;
endpackage

// File: rtl/dmi_state.sv
module dmi_state #(
  parameter int NUM_SRC = 64,
  parameter int NUM_CPU = 2,
  localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              en_set,
  input  logic                              en_clr,
  input  logic                              msk_set,
  input  logic                              msk_clr,
  input  logic [CPU_W-1:0]                  cpu_sel,
  input  logic [dmi_pkg::ID_W-1:0]          id,
  input  logic                              rt_we,
  input  logic [SRC_W-1:0]                  rt_idx,
  input  logic [31:0]                       rt_wdata,
  output logic [NUM_SRC-1:0]                en_vec,
  output logic [NUM_CPU-1:0][NUM_SRC-1:0]   mask_mat,
  output logic [NUM_SRC-1:0][7:0]           route
);
  localparam logic [3:0] CPU_BITS = 4'((1 << NUM_CPU) - 1);

  logic             id_ok;
  logic             cpu_ok;
  logic [SRC_W-1:0] id_idx;

  assign id_ok  = int'(id) < NUM_SRC;
  assign cpu_ok = int'(cpu_sel) < NUM_CPU;
  assign id_idx = id[SRC_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      en_vec <= '0;
    end else if (en_set && id_ok) begin
      en_vec[id_idx] <= 1'b1;
    end else if (en_clr && id_ok) begin
      en_vec[id_idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_mat <= '1;
    end else begin
      for (int c = 0; c < NUM_CPU; c++) begin
        if (cpu_ok && id_ok && (int'(cpu_sel) == c)) begin
          if (msk_set)      mask_mat[c][id_idx] <= 1'b1;
          else if (msk_clr) mask_mat[c][id_idx] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      route <= '0;
    end else if (rt_we) begin
      route[rt_idx] <= {CPU_BITS & rt_wdata[11:8], CPU_BITS & rt_wdata[3:0]};
    end
  end

  // R2
  en_set_takes_chk: assert property (@(posedge clk) disable iff (rst)
    (en_set && id_ok) |=> en_vec[$past(id_idx)]);

  // R2
  en_clr_takes_chk: assert property (@(posedge clk) disable iff (rst)
    (en_clr && id_ok) |=> !en_vec[$past(id_idx)]);

  // R2
  en_range_chk: assert property (@(posedge clk) disable iff (rst)
    ((en_set || en_clr) && !id_ok) |=> $stable(en_vec));

  // R3
  msk_clr_takes_chk: assert property (@(posedge clk) disable iff (rst)
    (msk_clr && id_ok && cpu_ok) |=> !mask_mat[$past(cpu_sel)][$past(id_idx)]);
endmodule

// File: rtl/dmi_cpu_path.sv
module dmi_cpu_path #(
  parameter int NUM_SRC = 64,
  parameter int CPU_IDX = 0,
  localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_SRC-1:0]            src_level,
  input  logic [NUM_SRC-1:0]            en_vec,
  input  logic [NUM_SRC-1:0]            mask_row,
  input  logic [NUM_SRC-1:0][7:0]       route,
  output logic [NUM_SRC-1:0]            elig,
  output logic [dmi_pkg::ID_W-1:0]      low_id,
  output logic                          irq
);
  import dmi_pkg::*;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    assign elig[s] = src_level[s] & en_vec[s] & ~mask_row[s]
                   & (route[s][CPU_IDX] | route[s][4+CPU_IDX]);
  end

  always_comb begin
    low_id = SPURIOUS_ID;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (elig[i]) low_id = ID_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |elig;
  end

  // R6
  irq_needs_line_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(|src_level));

  // R5
  irq_needs_gates_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(|(en_vec & ~mask_row)));

  // R7
  ack_is_live_chk: assert property (@(posedge clk) disable iff (rst)
    (low_id != SPURIOUS_ID) |-> (src_level[low_id[SRC_W-1:0]]
      && en_vec[low_id[SRC_W-1:0]] && !mask_row[low_id[SRC_W-1:0]]));
endmodule

// File: rtl/dual_mask_intc.sv
module dual_mask_intc #(
  parameter int NUM_SRC = 64,
  parameter int NUM_CPU = 2,
  parameter int ADDR_W  = 12,
  localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_level,
  input  logic               bus_valid,
  input  logic               bus_write,
  input  logic               bus_local,
  input  logic [CPU_W-1:0]   bus_cpu,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               bus_rvalid,
  output logic [NUM_CPU-1:0] cpu_irq
);
  import dmi_pkg::*;

  localparam int CAUSE_N = (NUM_SRC < LOCAL_LIMIT) ? NUM_SRC : LOCAL_LIMIT;

  logic wr_req, rd_req, shared_win, local_win, cpu_ok;
  logic en_set, en_clr, msk_set, msk_clr;
  logic rt_hit, rt_we;
  logic [ADDR_W-1:0] rt_off, rt_word;
  logic [SRC_W-1:0]  rt_idx;

  logic [NUM_SRC-1:0]                en_vec;
  logic [NUM_CPU-1:0][NUM_SRC-1:0]   mask_mat;
  logic [NUM_SRC-1:0][7:0]           route;
  logic [NUM_CPU-1:0][NUM_SRC-1:0]   elig_all;
  logic [NUM_CPU-1:0][ID_W-1:0]      low_all;
  logic [NUM_CPU-1:0][31:0]          cause_all;
  logic [31:0]                       rd_mux;

  assign wr_req     = bus_valid & bus_write;
  assign rd_req     = bus_valid & ~bus_write;
  assign shared_win = ~bus_local;
  assign local_win  = bus_local;
  assign cpu_ok     = int'(bus_cpu) < NUM_CPU;

  assign en_set  = wr_req & shared_win & (bus_addr == ADDR_W'(OFS_EN_SET));
  assign en_clr  = wr_req & shared_win & (bus_addr == ADDR_W'(OFS_EN_CLR));
  assign msk_set = wr_req & local_win  & (bus_addr == ADDR_W'(OFS_MSK_SET));
  assign msk_clr = wr_req & local_win  & (bus_addr == ADDR_W'(OFS_MSK_CLR));

  assign rt_off  = bus_addr - ADDR_W'(OFS_ROUTE);
  assign rt_word = rt_off >> 2;
  assign rt_idx  = rt_word[SRC_W-1:0];
  assign rt_hit  = shared_win && (bus_addr >= ADDR_W'(OFS_ROUTE))
                && (bus_addr[1:0] == 2'b00) && (int'(rt_word) < NUM_SRC);
  assign rt_we   = wr_req & rt_hit;

  dmi_state #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) u_state (
    .clk      (clk),
    .rst      (rst),
    .en_set   (en_set),
    .en_clr   (en_clr),
    .msk_set  (msk_set),
    .msk_clr  (msk_clr),
    .cpu_sel  (bus_cpu),
    .id       (bus_wdata[ID_W-1:0]),
    .rt_we    (rt_we),
    .rt_idx   (rt_idx),
    .rt_wdata (bus_wdata),
    .en_vec   (en_vec),
    .mask_mat (mask_mat),
    .route    (route)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    dmi_cpu_path #(.NUM_SRC(NUM_SRC), .CPU_IDX(c)) u_path (
      .clk       (clk),
      .rst       (rst),
      .src_level (src_level),
      .en_vec    (en_vec),
      .mask_row  (mask_mat[c]),
      .route     (route),
      .elig      (elig_all[c]),
      .low_id    (low_all[c]),
      .irq       (cpu_irq[c])
    );
    if (CAUSE_N < 32) begin : g_pad
      assign cause_all[c] = {{(32-CAUSE_N){1'b0}}, elig_all[c][CAUSE_N-1:0]};
    end else begin : g_full
      assign cause_all[c] = elig_all[c][31:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (shared_win) begin
      if (bus_addr == ADDR_W'(OFS_CTRL)) begin
        rd_mux[12:2] = 11'(NUM_SRC);
      end else if (rt_hit) begin
        rd_mux[11:8] = route[rt_idx][7:4];
        rd_mux[3:0]  = route[rt_idx][3:0];
      end
    end else if (cpu_ok) begin
      if (bus_addr == ADDR_W'(OFS_CAUSE)) begin
        rd_mux = cause_all[bus_cpu];
      end else if (bus_addr == ADDR_W'(OFS_ACK)) begin
        rd_mux[ID_W-1:0] = low_all[bus_cpu];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd_req;
      if (rd_req) bus_rdata <= rd_mux;
    end
  end

  // R9
  rd_answer_chk: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> bus_rvalid);

  // R1
  count_field_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req && shared_win && bus_addr == ADDR_W'(OFS_CTRL))
      |=> (bus_rdata[12:2] == 11'(NUM_SRC)));
endmodule

// File: tb/test_dual_mask_intc.sv
`timescale 1ns/100ps
module test_dual_mask_intc;
  localparam int NS = 40;
  localparam int NC = 2;

  logic        clk = 1'b0;
  logic        rst;
  logic [NS-1:0] src;
  logic        bv, bw, bl;
  logic [0:0]  bcpu;
  logic [11:0] baddr;
  logic [31:0] bwd;
  logic [31:0] rdata;
  logic        rvalid;
  logic [NC-1:0] irq;

  int compared = 0;
  int mismatched = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  dual_mask_intc #(.NUM_SRC(NS), .NUM_CPU(NC), .ADDR_W(12)) i_dual_mask_intc (
    .clk(clk), .rst(rst), .src_level(src),
    .bus_valid(bv), .bus_write(bw), .bus_local(bl), .bus_cpu(bcpu),
    .bus_addr(baddr), .bus_wdata(bwd),
    .bus_rdata(rdata), .bus_rvalid(rvalid), .cpu_irq(irq)
  );

  // monitor: pops expected read data as results appear
  always @(negedge clk) begin : monitor
    logic [31:0] e;
    string t;
    if (!rst && rvalid) begin
      compared++;
      if (exp_q.size() == 0) begin
        mismatched++;
        $display("FAIL R9 unexpected read data: actual=%h expected=none", rdata);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          mismatched++;
          $display("FAIL %s: actual=%h expected=%h", t, rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic loc, input logic c, input int a, input logic [31:0] d);
    bv = 1'b1; bw = 1'b1; bl = loc; bcpu = c; baddr = 12'(a); bwd = d;
    @(negedge clk);
    bv = 1'b0; bw = 1'b0;
  endtask

  task automatic rd(input logic loc, input logic c, input int a,
                    input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    bv = 1'b1; bw = 1'b0; bl = loc; bcpu = c; baddr = 12'(a); bwd = '0;
    @(negedge clk);
    bv = 1'b0;
  endtask

  task automatic check_irq(input logic [NC-1:0] e, input string t);
    @(negedge clk);
    compared++;
    if (irq !== e) begin
      mismatched++;
      $display("FAIL %s: actual=%b expected=%b", t, irq, e);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL R10 watchdog: actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin : driver
    rst = 1'b1; src = '0; bv = 0; bw = 0; bl = 0; bcpu = 0; baddr = 0; bwd = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R10 reset state, R1 count
    rd(0, 0, 'h000, 32'd160, "R1 source count");
    rd(1, 0, 'h044, 32'd1023, "R10 ack cpu0 after reset");
    rd(1, 1, 'h044, 32'd1023, "R10 ack cpu1 after reset");
    rd(0, 0, 'h114, 32'd0, "R10 control word after reset");
    check_irq(2'b00, "R10 irq after reset");

    // enabled and routed but still masked
    src[5] = 1'b1; src[3] = 1'b1;
    wr(0, 0, 'h030, 5);
    wr(0, 0, 'h114, 32'h1);
    check_irq(2'b00, "R3 masked source held back");
    rd(1, 0, 'h044, 32'd1023, "R5 masked source not acked");

    wr(1, 0, 'h04C, 5);
    check_irq(2'b01, "R6 cpu0 irq");
    rd(1, 0, 'h044, 32'd5, "R7 ack id 5");
    rd(1, 1, 'h044, 32'd1023, "R3 cpu1 unaffected");
    rd(1, 0, 'h010, 32'h20, "R8 cause bit 5");

    // lowest ID wins, read has no side effect
    wr(0, 0, 'h030, 3);
    wr(0, 0, 'h10C, 32'h1);
    wr(1, 0, 'h04C, 3);
    rd(1, 0, 'h044, 32'd3, "R7 lowest id first");
    rd(1, 0, 'h044, 32'd3, "R7 repeat read same id");
    rd(1, 0, 'h010, 32'h28, "R8 cause bits 3 and 5");

    wr(0, 0, 'h034, 3);
    rd(1, 0, 'h044, 32'd5, "R2 clear-enable of 3");

    // out-of-range ID aliasing source 5 in its low bits
    wr(0, 0, 'h034, 69);
    rd(1, 0, 'h044, 32'd5, "R2 out-of-range id ignored");

    wr(1, 0, 'h048, 5);
    rd(1, 0, 'h044, 32'd1023, "R3 mask set");
    check_irq(2'b00, "R6 irq drops after mask");

    // source above 28 routed through FIQ bit to cpu1
    src[35] = 1'b1;
    wr(0, 0, 'h030, 35);
    wr(0, 0, 'h18C, 32'h200);
    wr(1, 1, 'h04C, 35);
    check_irq(2'b10, "R5 fiq route delivers");
    rd(1, 1, 'h044, 32'd35, "R5 ack id 35 on cpu1");
    rd(1, 1, 'h010, 32'h0, "R8 id above 28 not in cause");
    rd(0, 0, 'h18C, 32'h200, "R4 control readback");

    wr(0, 0, 'h11C, 32'hFFFF_FFFF);
    rd(0, 0, 'h11C, 32'h303, "R4 unimplemented bits read zero");

    // reroute 5 to cpu1; cpu0 keeps it masked
    wr(1, 1, 'h04C, 5);
    wr(0, 0, 'h114, 32'h2);
    rd(1, 1, 'h044, 32'd5, "R7 cpu1 lowest is 5");
    check_irq(2'b10, "R3 cpu0 still masked");

    // level drop
    src[35] = 1'b0; src[5] = 1'b0;
    check_irq(2'b00, "R6 lines low");
    rd(1, 1, 'h044, 32'd1023, "R7 none pending");

    // unmapped and read-only
    rd(0, 0, 'h050, 32'h0, "R9 unmapped offset");
    rd(0, 0, 'h1A0, 32'h0, "R9 word past last source");
    wr(0, 0, 'h000, 32'hFFFF);
    rd(0, 0, 'h000, 32'd160, "R1 count not writable");

    // registered output: no change before the edge
    src[5] = 1'b1;
    #1;
    compared++;
    if (irq !== 2'b00) begin
      mismatched++;
      $display("FAIL R6 irq before edge: actual=%b expected=00", irq);
    end
    check_irq(2'b10, "R6 irq after one edge");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      compared++;
      mismatched++;
      $display("FAIL R9 missing reads: actual=%0d left expected=0", exp_q.size());
    end
    summary();
    $finish;
  end
endmodule